// File: doc/BRIEF.md
# Hot-Plug Expander Link Controller

This block keeps the hot-plug control and status signals of two downstream switch ports in step with an external I/O expander. The expander sits on an SMBus segment driven by a shared byte-level master engine, which also serves the configuration loader. The block holds a shadow of the last output image it sent. Whenever the live control image from the ports differs from that shadow, it writes the complete output byte to the expander.

The expander reports input changes on an active-low interrupt line, which enters the block asynchronously. While that line is low, the block reads the whole input byte and presents its contents as per-port status. Every transaction is preceded by a bus request, and no transaction starts until the grant arrives. A transaction that is refused with a NACK is repeated a bounded number of times. If it is still refused, it is abandoned and a sticky error is raised.

Top module: `hp_expander_ctl`

## Requirements
- R1: While reset is asserted, and until `cfg_done` has been seen high, `bus_req` and `txn_start` stay low and no transaction is attempted. Out of reset, `port_sts` is 0 and `hp_err` is 0.
- R2: A write carries the full output image in `txn_wdata`. Port p uses nibble bits [4p+3:4p]: bit 0 is power enable (`port_ctl[3p]`), bit 1 is power indicator (`port_ctl[3p+1]`), bit 2 is attention indicator (`port_ctl[3p+2]`), and bit 3 is 0. The write is sent even when only one bit changed.
- R3: A write is issued once for each change of the control image. While the image stays equal to the last image launched, no further write occurs.
- R4: While the synchronized `exp_int_n` is low, a read is issued. A successful read copies `txn_rdata` to `port_sts`, with port p in bits [4p+3:4p]: bit 0 presence, bit 1 button, bit 2 latch sensor, bit 3 power fault.
- R5: `txn_start` is raised only while `bus_gnt` is high. `bus_req` stays high from the request until the transaction ends, and it drops for at least one cycle after each transaction ends. Without a grant, nothing starts.
- R6: `txn_addr` equals `exp_addr`. `txn_cmd` equals `cmd_out` for writes (`txn_rd`=0) and `cmd_in` for reads (`txn_rd`=1).
- R7: When a write and a read are both pending at the choice point, the write is issued first.
- R8: The interrupt is level-sensitive. If it is still low when a read completes, another read follows.
- R9: A control change or interrupt that arrives during an in-flight transaction is serviced after that transaction completes.
- R10: After a NACK, the same transaction is repeated with the same direction and data, up to 3 retries.
- R11: A NACK on the final retry drops the transaction and sets `hp_err`, which stays set until reset. A failed read leaves `port_sts` unchanged, and a dropped write is not re-sent until the image changes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Configuration load has finished |
| exp_addr | input | 7 | Expander bus address (static) |
| cmd_out | input | 8 | Command code for output register writes (static) |
| cmd_in | input | 8 | Command code for input register reads (static) |
| port_ctl | input | 6 | Per-port control bits, 3 per port |
| port_sts | output | 8 | Per-port input status, 4 per port |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| bus_req | output | 1 | Request for the shared SMBus master |
| bus_gnt | input | 1 | Grant from the arbiter |
| txn_start | output | 1 | One-cycle pulse that launches a transaction |
| txn_rd | output | 1 | 1 = read, 0 = write |
| txn_addr | output | 7 | Target address |
| txn_cmd | output | 8 | Command byte |
| txn_wdata | output | 8 | Write data byte |
| txn_done | input | 1 | Transaction completed (pulse) |
| txn_nack | input | 1 | Completed transaction was refused (valid with done) |
| txn_rdata | input | 8 | Read data byte (valid with done) |
| hp_err | output | 1 | Sticky: a transaction was abandoned |

## Verification
The assertions assume the following about the master side. `txn_done` pulses only after a `txn_start` and never during the start cycle. `bus_gnt` stays high for as long as `bus_req` is held, and `cfg_done` does not fall once it has risen. The bench master model raises its grant one cycle after seeing the request, while the bench enables the grant. It answers each start with a single done pulse four cycles later and chooses the NACK from a bench-set attempt window. The bench raises `cfg_done` only once and holds it. It changes the interrupt and control inputs only on the falling clock edge.

// File: rtl/hp_expander_ctl.sv
module hp_expander_ctl #(
  parameter int NPORTS    = 2,
  parameter int CTL_W     = 3,
  parameter int NIB_W     = 4,
  parameter int MAX_RETRY = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_done,
  input  logic [6:0]                exp_addr,
  input  logic [7:0]                cmd_out,
  input  logic [7:0]                cmd_in,
  input  logic [NPORTS*CTL_W-1:0]   port_ctl,
  output logic [NPORTS*NIB_W-1:0]   port_sts,
  input  logic                      exp_int_n,
  output logic                      bus_req,
  input  logic                      bus_gnt,
  output logic                      txn_start,
  output logic                      txn_rd,
  output logic [6:0]                txn_addr,
  output logic [7:0]                txn_cmd,
  output logic [NPORTS*NIB_W-1:0]   txn_wdata,
  input  logic                      txn_done,
  input  logic                      txn_nack,
  input  logic [NPORTS*NIB_W-1:0]   txn_rdata,
  output logic                      hp_err
);

  localparam int IMG_W = NPORTS * NIB_W;
  localparam int RC_W  = $clog2(MAX_RETRY + 1);
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(MAX_RETRY);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_START, S_WAIT} state_t;

  state_t            state;
  logic              int_meta, int_sync;
  logic [IMG_W-1:0]  cur_img, sent_img;
  logic [RC_W-1:0]   retry_cnt;
  logic              wr_need, rd_need;

  genvar p;
  generate
    for (p = 0; p < NPORTS; p++) begin : g_img
      assign cur_img[p*NIB_W +: NIB_W] = {{(NIB_W-CTL_W){1'b0}}, port_ctl[p*CTL_W +: CTL_W]};
    end
  endgenerate

  assign wr_need   = (cur_img != sent_img);
  assign rd_need   = !int_sync;
  assign bus_req   = (state != S_IDLE);
  assign txn_start = (state == S_START);
  assign txn_addr  = exp_addr;
  assign txn_cmd   = txn_rd ? cmd_in : cmd_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_meta <= 1'b1;
      int_sync <= 1'b1;
    end else begin
      int_meta <= exp_int_n;
      int_sync <= int_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sent_img  <= '0;
      txn_rd    <= 1'b0;
      txn_wdata <= '0;
      retry_cnt <= '0;
      port_sts  <= '0;
      hp_err    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          retry_cnt <= '0;
          if (cfg_done) begin
            if (wr_need) begin
              txn_rd    <= 1'b0;
              txn_wdata <= cur_img;
              sent_img  <= cur_img;
              state     <= S_REQ;
            end else if (rd_need) begin
              txn_rd <= 1'b1;
              state  <= S_REQ;
            end
          end
        end
        S_REQ:   if (bus_gnt) state <= S_START;
        S_START: state <= S_WAIT;
        S_WAIT: begin
          if (txn_done) begin
            if (txn_nack) begin
              if (retry_cnt < RC_MAX) begin
                retry_cnt <= retry_cnt + 1'b1;
                state     <= S_START;
              end else begin
                hp_err <= 1'b1;
                state  <= S_IDLE;
              end
            end else begin
              if (txn_rd) port_sts <= txn_rdata;
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> bus_gnt); // R5

  AST_REQ_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cfg_done)); // R1

  AST_RELEASE_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && !txn_nack && bus_req) |=> !bus_req); // R5

  AST_RETRY_SAME_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && $past(bus_req) && $past(state) == S_WAIT) |-> ($stable(txn_rd) && $stable(txn_wdata))); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hp_err |=> hp_err); // R11

  AST_STS_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_sts) |-> $past(txn_done && !txn_nack && txn_rd)); // R4

endmodule

// File: tb/hp_expander_ctl_tb.sv
`timescale 1ns/1ps
module hp_expander_ctl_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cfg_done, exp_int_n;
  logic [6:0] exp_addr;
  logic [7:0] cmd_out, cmd_in;
  logic [5:0] port_ctl;
  logic [7:0] port_sts;
  logic       bus_req, bus_gnt, txn_start, txn_rd, txn_done, txn_nack, hp_err;
  logic [6:0] txn_addr;
  logic [7:0] txn_cmd, txn_wdata, txn_rdata;

  hp_expander_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .exp_addr(exp_addr),
    .cmd_out(cmd_out), .cmd_in(cmd_in), .port_ctl(port_ctl), .port_sts(port_sts),
    .exp_int_n(exp_int_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .txn_start(txn_start), .txn_rd(txn_rd), .txn_addr(txn_addr), .txn_cmd(txn_cmd),
    .txn_wdata(txn_wdata), .txn_done(txn_done), .txn_nack(txn_nack),
    .txn_rdata(txn_rdata), .hp_err(hp_err)
  );

  // master model
  logic       gnt_en;
  int         nack_until;
  logic [7:0] rd_val;
  int         n_att = 0, n_wr = 0, n_rd = 0, att_idx = 0, dly = 0, bad_start = 0;
  logic       busy = 1'b0, cur_rd = 1'b0;
  logic       att_kind [0:63];
  logic [7:0] last_wdata = '0, wr_cmd = '0, rd_cmd = '0;
  logic [6:0] last_addr = '0;

  always @(posedge clk) begin
    bus_gnt  <= bus_req && gnt_en;
    txn_done <= 1'b0;
    txn_nack <= 1'b0;
    if (txn_start) begin
      if (!bus_gnt) bad_start <= bad_start + 1;
      busy    <= 1'b1;
      dly     <= 3;
      cur_rd  <= txn_rd;
      att_idx <= n_att;
      att_kind[n_att % 64] <= txn_rd;
      n_att   <= n_att + 1;
      last_addr <= txn_addr;
      if (txn_rd) rd_cmd <= txn_cmd;
      else begin wr_cmd <= txn_cmd; last_wdata <= txn_wdata; end
    end else if (busy) begin
      if (dly == 0) begin
        busy      <= 1'b0;
        txn_done  <= 1'b1;
        txn_rdata <= rd_val;
        if (att_idx < nack_until) txn_nack <= 1'b1;
        else if (cur_rd) n_rd <= n_rd + 1;
        else n_wr <= n_wr + 1;
      end else dly <= dly - 1;
    end
  end

  int vecs = 0, errs = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 2000 && quiet < 12; i++) begin
      @(negedge clk);
      if (bus_req || busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset bus_req", bus_req, 0);
    chk("R1 reset sts", port_sts, 8'h00);
    chk("R1 reset err", hp_err, 0);
  endtask

  task automatic t_precfg();
    port_ctl  = {3'b011, 3'b101};
    rd_val    = 8'hA6;
    exp_int_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 no attempt before cfg", n_att, 0);
    chk("R1 no request before cfg", bus_req, 0);
  endtask

  task automatic t_first();
    int base = n_att;
    cfg_done = 1'b1;
    for (int i = 0; i < 200 && n_att < base + 2; i++) @(negedge clk);
    exp_int_n = 1'b1;
    wait_idle();
    chk("R7 write first", att_kind[base], 0);
    chk("R7 read second", att_kind[base+1], 1);
    chk("R2 full image", last_wdata, 8'h35);
    chk("R4 status", port_sts, 8'hA6);
    chk("R6 addr", last_addr, 7'h27);
    chk("R6 write cmd", wr_cmd, 8'h1A);
    chk("R6 read cmd", rd_cmd, 8'h2B);
  endtask

  task automatic t_quiet();
    int base = n_att;
    repeat (40) @(negedge clk);
    chk("R3 no repeat write", n_att, base);
  endtask

  task automatic t_one_bit();
    int w = n_wr;
    port_ctl = {3'b111, 3'b101};
    wait_idle();
    chk("R3 one write", n_wr, w + 1);
    chk("R2 one-bit change full byte", last_wdata, 8'h75);
  endtask

  task automatic t_no_grant();
    int base = n_att;
    gnt_en   = 1'b0;
    port_ctl = {3'b000, 3'b010};
    repeat (30) @(negedge clk);
    chk("R5 request held", bus_req, 1);
    chk("R5 no start w/o grant", n_att, base);
    gnt_en = 1'b1;
    wait_idle();
    chk("R5 write after grant", last_wdata, 8'h02);
  endtask

  task automatic t_level();
    int r = n_rd;
    rd_val    = 8'h5C;
    exp_int_n = 1'b0;
    for (int i = 0; i < 400 && n_rd < r + 2; i++) @(negedge clk);
    exp_int_n = 1'b1;
    wait_idle();
    chk("R8 repeated read", (n_rd - r) >= 2, 1);
    chk("R4 status level", port_sts, 8'h5C);
  endtask

  task automatic t_inflight();
    int base = n_att;
    int w = n_wr;
    rd_val    = 8'h91;
    exp_int_n = 1'b0;
    for (int i = 0; i < 200 && n_att == base; i++) @(negedge clk);
    port_ctl  = {3'b001, 3'b100};
    exp_int_n = 1'b1;
    wait_idle();
    chk("R9 read first", att_kind[base], 1);
    chk("R9 deferred write", att_kind[base+1], 0);
    chk("R9 write count", n_wr, w + 1);
    chk("R9 write data", last_wdata, 8'h14);
    chk("R9 status", port_sts, 8'h91);
  endtask

  task automatic t_retry_ok();
    int base = n_att;
    int w = n_wr;
    nack_until = n_att + 2;
    port_ctl   = {3'b110, 3'b001};
    wait_idle();
    chk("R10 attempts", n_att - base, 3);
    chk("R10 success", n_wr, w + 1);
    chk("R10 data", last_wdata, 8'h61);
    chk("R10 no error", hp_err, 0);
  endtask

  task automatic t_retry_fail();
    int base = n_att;
    int w = n_wr;
    int r = n_rd;
    nack_until = n_att + 4;
    port_ctl   = {3'b010, 3'b011};
    wait_idle();
    chk("R11 attempts", n_att - base, 4);
    chk("R11 no write done", n_wr, w);
    chk("R11 err set", hp_err, 1);
    base = n_att;
    repeat (40) @(negedge clk);
    chk("R11 dropped", n_att, base);
    nack_until = n_att + 4;
    rd_val     = 8'h3E;
    exp_int_n  = 1'b0;
    for (int i = 0; i < 400 && n_att < base + 4; i++) @(negedge clk);
    exp_int_n = 1'b1;
    wait_idle();
    chk("R11 failed read keeps sts", port_sts, 8'h91);
    nack_until = 0;
    rd_val     = 8'h3E;
    exp_int_n  = 1'b0;
    for (int i = 0; i < 400 && n_rd == r; i++) @(negedge clk);
    exp_int_n = 1'b1;
    wait_idle();
    chk("R4 read after error", port_sts, 8'h3E);
    chk("R11 err sticky", hp_err, 1);
    chk("R5 starts granted", bad_start, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_done = 1'b0; exp_int_n = 1'b1; port_ctl = '0;
    exp_addr = 7'h27; cmd_out = 8'h1A; cmd_in = 8'h2B;
    gnt_en = 1'b1; nack_until = 0; rd_val = '0; txn_rdata = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_precfg();
    t_first();
    t_quiet();
    t_one_bit();
    t_no_grant();
    t_level();
    t_inflight();
    t_retry_ok();
    t_retry_fail();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule